// File: doc/BRIEF.md
# Bit-Band Alias Access Bridge

The bridge sits between a bus master and backing memory and gives single-bit access to two regions of that memory. Each region has an alias window of 32 MB. Every 32-bit word inside a window stands for exactly one bit of the backing region. Reading an alias word returns that bit as 0 or 1. Writing an alias word sets or clears that one bit and leaves every other bit alone. The bridge does this with a read-modify-write sequence on its master port.

The slave side is a plain request/response port. It carries an address, a write flag, an access size (byte, halfword or word) and write data. The master side issues sized, byte-strobed requests to memory and waits for one response per request. The access size picks two things: how many address bits form the bit index, and how the backing address is aligned. The backing read and the backing write both use the same size as the alias access. An address that falls outside both windows is not forwarded. The bridge answers it at once with a miss flag.

Top module: `bitband_bridge`

## Requirements
- R1: An address hits window 0 when its bits [31:25] equal those of 0x22000000, and window 1 when they equal those of 0x42000000. Window 0 is backed at 0x20000000 and window 1 at 0x40000000.
- R2: The backing byte address is the backing base OR'd with (alias address bits [24:0]) shifted right by 5. A halfword access then clears address bit 0 and a word access clears bits [1:0]. The master size code equals the slave size code (0 byte, 1 halfword, 2 word).
- R3: The bit index is alias address bits [6:2], masked to its low 3 bits for a byte, 4 bits for a halfword and 5 bits for a word. It selects that bit of the little-endian value read at the aligned backing address.
- R4: A read makes exactly one backing read. Its response carries the selected bit in s_rdata bit 0, with all other bits zero.
- R5: A write makes one backing read, then one backing write. The write sets the selected bit to s_wdata bit 0 and leaves every other bit of the accessed bytes unchanged. Its response carries s_rdata = 0.
- R6: Byte lanes are little-endian. Memory byte A travels on m_rdata and m_wdata bits [8*A[1:0]+7 : 8*A[1:0]]. m_strb bit i is set only for the lanes the access covers: 1, 2 or 4 lanes starting at lane m_addr[1:0].
- R7: s_req_ready is low from the cycle after a request is accepted until the cycle its response appears. Each accepted request gets exactly one s_rsp_valid pulse, one cycle long.
- R8: An address outside both windows makes no backing request. One cycle after acceptance it gets a response with s_miss = 1 and s_rdata = 0.
- R9: After reset, s_req_ready is 1, and m_req_valid and s_rsp_valid are 0.
- R10: A backing request holds m_req_valid, m_addr, m_write and m_strb unchanged until a cycle in which m_req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req_valid | input | 1 | Slave request present |
| s_req_ready | output | 1 | Bridge can accept a request |
| s_addr | input | ADDR_W | Alias byte address |
| s_write | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | 0 byte, 1 halfword, 2 word (3 treated as word) |
| s_wdata | input | DATA_W | Write data; only bit 0 is used |
| s_rsp_valid | output | 1 | One-cycle response pulse |
| s_rdata | output | DATA_W | Selected bit in bit 0 for reads, else zero |
| s_miss | output | 1 | Response is for an address outside both windows |
| m_req_valid | output | 1 | Backing request present |
| m_req_ready | input | 1 | Backing memory takes the request |
| m_addr | output | ADDR_W | Aligned backing byte address |
| m_write | output | 1 | Backing request is a write |
| m_size | output | 2 | Backing access size, same codes as s_size |
| m_wdata | output | DATA_W | Backing write word |
| m_strb | output | DATA_W/8 | Byte-lane enables |
| m_rsp_valid | input | 1 | Backing response (read data or write done) |
| m_rdata | input | DATA_W | Backing read word |

## Verification
A wrong captured bit position or lane shows up in one of two places. It appears in s_rdata on the next read of that alias word. It also appears in the backing memory as a changed neighbouring bit, right after the write that follows. A bad sequencer state shows up within a cycle or two: a backing request while s_req_ready is high, a missing or doubled response pulse, or the wrong number of backing requests per access. The bench keeps its own copy of the backing memory. It checks the backing address and size on every request, every read result, and all four bytes around every written location.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } bb_size_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_WR_WAIT = 3'd4
  } bb_state_e;

  // Reserved size code behaves as a full word.
  function automatic logic [1:0] bb_clamp_size(input logic [1:0] sz);
    return (sz == SZ_RSVD) ? SZ_WORD : sz;
  endfunction

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode #(
  parameter int ADDR_W    = 32,
  parameter int NUM_WIN   = 2,
  parameter int WIN_LOG2  = 25,
  parameter int BIT_SHIFT = 5,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] byte_addr
);

  localparam int TAG_W = ADDR_W - WIN_LOG2;

  logic [NUM_WIN-1:0] win_hit;
  logic [ADDR_W-1:0]  win_addr [NUM_WIN];
  logic [ADDR_W-1:0]  offset;

  assign offset = {{TAG_W{1'b0}}, addr[WIN_LOG2-1:0]};

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign win_hit[g]  = (addr[ADDR_W-1:WIN_LOG2] ==
                          ALIAS_BASES[g*ADDR_W+WIN_LOG2 +: TAG_W]);
    assign win_addr[g] = BACK_BASES[g*ADDR_W +: ADDR_W] | (offset >> BIT_SHIFT);
  end

  // Lowest-numbered window wins if bases ever overlap.
  always_comb begin
    hit       = 1'b0;
    byte_addr = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        hit       = 1'b1;
        byte_addr = win_addr[i];
      end
    end
  end

endmodule

// File: rtl/bb_lane_map.sv
module bb_lane_map
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]           byte_addr,
  input  logic [$clog2(DATA_W)-1:0]   bit_sel,
  input  logic [1:0]                  size,
  output logic [ADDR_W-1:0]           aligned,
  output logic [DATA_W/8-1:0]         strb,
  output logic [$clog2(DATA_W)-1:0]   pos
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int POS_W  = $clog2(DATA_W);

  logic [1:0]        sz;
  logic [ADDR_W-1:0] align_mask;
  logic [POS_W-1:0]  idx_mask;
  logic [POS_W-1:0]  bit_in;
  logic [LANE_W-1:0] lane;

  always_comb begin
    sz         = bb_clamp_size(size);
    align_mask = ADDR_W'((1 << sz) - 1);
    aligned    = byte_addr & ~align_mask;
    idx_mask   = POS_W'((8 << sz) - 1);
    bit_in     = bit_sel & idx_mask;
    lane       = aligned[LANE_W-1:0];
    pos        = (POS_W'(lane) << 3) + bit_in;
    strb       = LANES'(((1 << (1 << sz)) - 1) << lane);
  end

endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      s_req_valid,
  input  logic                      s_write,
  input  logic [1:0]                s_size,
  input  logic                      wbit,
  input  logic                      hit,
  input  logic [ADDR_W-1:0]         xl_addr,
  input  logic [DATA_W/8-1:0]       xl_strb,
  input  logic [$clog2(DATA_W)-1:0] xl_pos,
  output logic                      s_req_ready,
  output logic                      s_rsp_valid,
  output logic [DATA_W-1:0]         s_rdata,
  output logic                      s_miss,
  output logic                      m_req_valid,
  input  logic                      m_req_ready,
  output logic [ADDR_W-1:0]         m_addr,
  output logic                      m_write,
  output logic [1:0]                m_size,
  output logic [DATA_W-1:0]         m_wdata,
  output logic [DATA_W/8-1:0]       m_strb,
  input  logic                      m_rsp_valid,
  input  logic [DATA_W-1:0]         m_rdata
);

  localparam int POS_W = $clog2(DATA_W);

  bb_state_e        state;
  logic [POS_W-1:0] cap_pos;
  logic             cap_bit;
  logic             cap_write;

  assign s_req_ready = (state == ST_IDLE);
  assign m_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign m_write     = (state == ST_WR_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      s_rsp_valid <= 1'b0;
      s_rdata     <= '0;
      s_miss      <= 1'b0;
      m_addr      <= '0;
      m_size      <= 2'd0;
      m_strb      <= '0;
      m_wdata     <= '0;
      cap_pos     <= '0;
      cap_bit     <= 1'b0;
      cap_write   <= 1'b0;
    end else begin
      s_rsp_valid <= 1'b0;
      s_miss      <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (s_req_valid) begin
            s_rdata <= '0;
            if (!hit) begin
              s_rsp_valid <= 1'b1;
              s_miss      <= 1'b1;
            end else begin
              m_addr    <= xl_addr;
              m_size    <= bb_clamp_size(s_size);
              m_strb    <= xl_strb;
              cap_pos   <= xl_pos;
              cap_bit   <= wbit;
              cap_write <= s_write;
              state     <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: begin
          if (m_req_ready) state <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (m_rsp_valid) begin
            if (cap_write) begin
              m_wdata          <= m_rdata;
              m_wdata[cap_pos] <= cap_bit;
              state            <= ST_WR_REQ;
            end else begin
              s_rdata     <= DATA_W'(m_rdata[cap_pos]);
              s_rsp_valid <= 1'b1;
              state       <= ST_IDLE;
            end
          end
        end
        ST_WR_REQ: begin
          if (m_req_ready) state <= ST_WR_WAIT;
        end
        ST_WR_WAIT: begin
          if (m_rsp_valid) begin
            s_rsp_valid <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_WIN  = 2,
  parameter int WIN_LOG2 = 25,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_req_valid,
  output logic                s_req_ready,
  input  logic [ADDR_W-1:0]   s_addr,
  input  logic                s_write,
  input  logic [1:0]          s_size,
  input  logic [DATA_W-1:0]   s_wdata,
  output logic                s_rsp_valid,
  output logic [DATA_W-1:0]   s_rdata,
  output logic                s_miss,
  output logic                m_req_valid,
  input  logic                m_req_ready,
  output logic [ADDR_W-1:0]   m_addr,
  output logic                m_write,
  output logic [1:0]          m_size,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_strb,
  input  logic                m_rsp_valid,
  input  logic [DATA_W-1:0]   m_rdata
);

  localparam int POS_W     = $clog2(DATA_W);
  // one alias word (4 bytes) per bit: 2 bits for the word, 3 for the bit-in-byte
  localparam int BIT_SHIFT = 5;

  logic                hit;
  logic [ADDR_W-1:0]   byte_addr;
  logic [ADDR_W-1:0]   xl_addr;
  logic [DATA_W/8-1:0] xl_strb;
  logic [POS_W-1:0]    xl_pos;
  logic                unused_wdata;

  assign unused_wdata = ^s_wdata[DATA_W-1:1];

  bb_window_decode #(
    .ADDR_W     (ADDR_W),
    .NUM_WIN    (NUM_WIN),
    .WIN_LOG2   (WIN_LOG2),
    .BIT_SHIFT  (BIT_SHIFT),
    .ALIAS_BASES(ALIAS_BASES),
    .BACK_BASES (BACK_BASES)
  ) u_decode (
    .addr     (s_addr),
    .hit      (hit),
    .byte_addr(byte_addr)
  );

  bb_lane_map #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_lanes (
    .byte_addr(byte_addr),
    .bit_sel  (s_addr[POS_W+1:2]),
    .size     (s_size),
    .aligned  (xl_addr),
    .strb     (xl_strb),
    .pos      (xl_pos)
  );

  bb_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .s_req_valid(s_req_valid),
    .s_write    (s_write),
    .s_size     (s_size),
    .wbit       (s_wdata[0]),
    .hit        (hit),
    .xl_addr    (xl_addr),
    .xl_strb    (xl_strb),
    .xl_pos     (xl_pos),
    .s_req_ready(s_req_ready),
    .s_rsp_valid(s_rsp_valid),
    .s_rdata    (s_rdata),
    .s_miss     (s_miss),
    .m_req_valid(m_req_valid),
    .m_req_ready(m_req_ready),
    .m_addr     (m_addr),
    .m_write    (m_write),
    .m_size     (m_size),
    .m_wdata    (m_wdata),
    .m_strb     (m_strb),
    .m_rsp_valid(m_rsp_valid),
    .m_rdata    (m_rdata)
  );

endmodule

// File: rtl/bitband_bridge_sva.sv
module bitband_bridge_sva #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                s_req_ready,
  input logic                s_rsp_valid,
  input logic [DATA_W-1:0]   s_rdata,
  input logic                s_miss,
  input logic                m_req_valid,
  input logic                m_req_ready,
  input logic [ADDR_W-1:0]   m_addr,
  input logic                m_write,
  input logic [1:0]          m_size,
  input logic [DATA_W-1:0]   m_wdata,
  input logic [DATA_W/8-1:0] m_strb,
  input logic                m_rsp_valid,
  input logic [DATA_W-1:0]   m_rdata
);

  localparam int LANES = DATA_W / 8;

  logic              rd_pending;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] lane_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pending <= 1'b0;
      rd_word    <= '0;
    end else begin
      if (m_req_valid && m_req_ready && !m_write) rd_pending <= 1'b1;
      if (m_rsp_valid && rd_pending) begin
        rd_pending <= 1'b0;
        rd_word    <= m_rdata;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) lane_bits[8*i +: 8] = {8{m_strb[i]}};
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> s_req_ready && !m_req_valid && !s_rsp_valid);                  // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    m_req_valid |-> !s_req_ready);                                                // R7
  AST_SINGLE_BIT_RESULT: assert property (@(posedge clk) disable iff (rst)
    s_rsp_valid |-> (s_rdata >> 1) == '0);                                        // R4
  AST_MISS_LOCAL: assert property (@(posedge clk) disable iff (rst)
    s_rsp_valid && s_miss |-> s_rdata == '0 && !m_req_valid);                     // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    m_req_valid && !m_req_ready |=> m_req_valid && $stable(m_addr)
                                    && $stable(m_write) && $stable(m_strb));      // R10
  AST_STRB_MATCH_SIZE: assert property (@(posedge clk) disable iff (rst)
    m_req_valid |-> $countones(m_strb) == (1 << m_size));                         // R6
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    m_req_valid |-> (m_addr & ADDR_W'((1 << m_size) - 1)) == '0);                 // R2
  AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    m_req_valid && m_write |-> $countones((m_wdata ^ rd_word) & lane_bits) <= 1); // R5

endmodule

bind bitband_bridge bitband_bridge_sva #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_sva (
  .clk        (clk),
  .rst        (rst),
  .s_req_ready(s_req_ready),
  .s_rsp_valid(s_rsp_valid),
  .s_rdata    (s_rdata),
  .s_miss     (s_miss),
  .m_req_valid(m_req_valid),
  .m_req_ready(m_req_ready),
  .m_addr     (m_addr),
  .m_write    (m_write),
  .m_size     (m_size),
  .m_wdata    (m_wdata),
  .m_strb     (m_strb),
  .m_rsp_valid(m_rsp_valid),
  .m_rdata    (m_rdata)
);

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/1ps
module bitband_bridge_bench;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int MEMB = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          s_req_valid = 1'b0;
  logic          s_req_ready;
  logic [AW-1:0] s_addr = '0;
  logic          s_write = 1'b0;
  logic [1:0]    s_size = 2'd0;
  logic [DW-1:0] s_wdata = '0;
  logic          s_rsp_valid;
  logic [DW-1:0] s_rdata;
  logic          s_miss;
  logic          m_req_valid;
  logic          m_req_ready;
  logic [AW-1:0] m_addr;
  logic          m_write;
  logic [1:0]    m_size;
  logic [DW-1:0] m_wdata;
  logic [3:0]    m_strb;
  logic          m_rsp_valid;
  logic [DW-1:0] m_rdata;

  always #2 clk = ~clk;

  bitband_bridge u_bitband_bridge (
    .clk(clk), .rst(rst),
    .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_addr(s_addr),
    .s_write(s_write), .s_size(s_size), .s_wdata(s_wdata),
    .s_rsp_valid(s_rsp_valid), .s_rdata(s_rdata), .s_miss(s_miss),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_addr(m_addr),
    .m_write(m_write), .m_size(m_size), .m_wdata(m_wdata), .m_strb(m_strb),
    .m_rsp_valid(m_rsp_valid), .m_rdata(m_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] mem  [2][MEMB];
  logic [7:0] refm [2][MEMB];

  logic          busy;
  int            lat;
  logic [DW-1:0] hold;
  int            n_acc;
  logic [AW-1:0] exp_maddr = '0;
  logic [1:0]    exp_msize = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] init_byte(input int r, input int i);
    return 8'(i * 37 + r * 101 + 5);
  endfunction

  // Backing memory model: little-endian lanes, random ready and latency.
  always @(posedge clk) begin
    if (rst) begin
      m_req_ready <= 1'b0;
      m_rsp_valid <= 1'b0;
      m_rdata     <= '0;
      busy        <= 1'b0;
      lat         <= 0;
      n_acc       <= 0;
      hold        <= '0;
      for (int r = 0; r < 2; r++)
        for (int i = 0; i < MEMB; i++) mem[r][i] <= init_byte(r, i);
    end else begin
      m_rsp_valid <= 1'b0;
      if (busy) begin
        m_req_ready <= 1'b0;
        if (lat == 0) begin
          m_rsp_valid <= 1'b1;
          m_rdata     <= hold;
          busy        <= 1'b0;
        end else lat <= lat - 1;
      end else if (m_req_valid && m_req_ready) begin
        int r, base;
        n_acc       <= n_acc + 1;
        busy        <= 1'b1;
        lat         <= $urandom_range(2, 0);
        m_req_ready <= 1'b0;
        chk("R1 R2 backing address", m_addr, exp_maddr);
        chk("R2 backing size", 32'(m_size), 32'(exp_msize));
        r    = int'(m_addr[30]);
        base = int'({m_addr[8:2], 2'b00});
        if (m_write) begin
          for (int i = 0; i < 4; i++)
            if (m_strb[i]) mem[r][base + i] <= m_wdata[8*i +: 8];
        end else begin
          hold <= {mem[r][base+3], mem[r][base+2], mem[r][base+1], mem[r][base]};
        end
      end else begin
        m_req_ready <= ($urandom_range(3, 0) != 0);
      end
    end
  end

  // Expected location from the requirements: little-endian value at aligned address.
  function automatic void ref_loc(input logic [31:0] a, input logic [1:0] sz,
                                  output int r, output int byte_i, output int bit_i,
                                  output logic [31:0] maddr);
    logic [31:0] bo, bi, al;
    r      = int'(a[30]);
    bo     = {12'b0, a[24:5]};
    bi     = (a >> 2) & ((32'd8 << sz) - 1);
    al     = bo & ~((32'd1 << sz) - 1);
    maddr  = (r == 1 ? 32'h4000_0000 : 32'h2000_0000) | al;
    byte_i = int'((al + bi / 8) % MEMB);
    bit_i  = int'(bi % 8);
  endfunction

  task automatic access(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output logic miss);
    bit early;
    early = 1'b0;
    @(negedge clk);
    s_addr = a; s_write = wr; s_size = sz; s_wdata = wd; s_req_valid = 1'b1;
    while (!s_req_ready) @(negedge clk);
    @(negedge clk);
    s_req_valid = 1'b0;
    while (!s_rsp_valid) begin
      if (s_req_ready) early = 1'b1;
      @(negedge clk);
    end
    rd   = s_rdata;
    miss = s_miss;
    chk("R7 ready low while busy", 32'(early), 32'd0);
    @(negedge clk);
    chk("R7 single response pulse", 32'(s_rsp_valid), 32'd0);
  endtask

  task automatic do_op(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                       input logic [31:0] wd);
    int r, bi8, bt, n0, wbase;
    logic [31:0] maddr, rd;
    logic miss;
    ref_loc(a, sz, r, bi8, bt, maddr);
    exp_maddr = maddr;
    exp_msize = sz;
    n0 = n_acc;
    access(a, wr, sz, wd, rd, miss);
    chk("R8 no miss inside window", 32'(miss), 32'd0);
    if (wr) begin
      refm[r][bi8][bt] = wd[0];
      chk("R5 write response data", rd, 32'd0);
      chk("R5 two backing requests", 32'(n_acc - n0), 32'd2);
      wbase = bi8 & ~3;
      for (int k = 0; k < 4; k++)
        chk("R5 R6 backing bytes after write", 32'(mem[r][wbase + k]), 32'(refm[r][wbase + k]));
    end else begin
      chk("R3 R4 read bit", rd, {31'b0, refm[r][bi8][bt]});
      chk("R4 one backing request", 32'(n_acc - n0), 32'd1);
    end
  endtask

  task automatic do_miss(input logic [31:0] a, input bit wr);
    int n0;
    logic [31:0] rd;
    logic miss;
    n0 = n_acc;
    access(a, wr, 2'd2, 32'd1, rd, miss);
    chk("R8 miss flag", 32'(miss), 32'd1);
    chk("R8 miss data", rd, 32'd0);
    chk("R8 no backing request", 32'(n_acc - n0), 32'd0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    int bits [4] = '{0, 7, 15, 31};
    void'($urandom(32'd20240611));
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < MEMB; i++) refm[r][i] = init_byte(r, i);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 ready after reset", 32'(s_req_ready), 32'd1);
    chk("R9 no backing request after reset", 32'(m_req_valid), 32'd0);
    chk("R9 no response after reset", 32'(s_rsp_valid), 32'd0);

    // Directed: bits 0, 7, 15, 31 at each size, both windows.
    for (int w = 0; w < 2; w++)
      for (int sz = 0; sz < 3; sz++)
        for (int b = 0; b < 4; b++) begin
          logic [31:0] a;
          a = (w == 1 ? 32'h4200_0000 : 32'h2200_0000)
              | (32'(8 * (sz * 4 + b) + 4) << 5) | (32'(bits[b]) << 2);
          do_op(a, 1'b0, 2'(sz), 32'd0);
          do_op(a, 1'b1, 2'(sz), 32'd1);
          do_op(a, 1'b0, 2'(sz), 32'd0);
          do_op(a, 1'b1, 2'(sz), 32'hFFFF_FFFE);
          do_op(a, 1'b0, 2'(sz), 32'd0);
        end

    // Top word of each window.
    do_op(32'h23FF_FFFC, 1'b1, 2'd2, 32'd1);
    do_op(32'h23FF_FFFC, 1'b0, 2'd2, 32'd0);
    do_op(32'h43FF_FFFC, 1'b1, 2'd0, 32'd0);
    do_op(32'h43FF_FFFC, 1'b0, 2'd0, 32'd0);
    do_op(32'h2200_0000, 1'b0, 2'd1, 32'd0);

    // Outside both windows.
    do_miss(32'h3000_0000, 1'b0);
    do_miss(32'h2400_0000, 1'b1);
    do_miss(32'h21FF_FFFC, 1'b0);
    do_miss(32'h0000_0000, 1'b1);
    do_miss(32'h4400_0000, 1'b0);

    // Constrained random mix.
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      a = ($urandom_range(1, 0) == 1 ? 32'h4200_0000 : 32'h2200_0000)
          | 32'($urandom_range(32'h3FFF, 0));
      do_op(a, $urandom_range(1, 0) == 1, 2'($urandom_range(2, 0)), $urandom);
      if (n % 50 == 0) do_miss(32'h6000_0000 | 32'($urandom_range(32'hFFFF, 0)), 1'b1);
    end

    begin
      int nm;
      nm = 0;
      for (int r = 0; r < 2; r++)
        for (int i = 0; i < MEMB; i++) if (mem[r][i] !== refm[r][i]) nm++;
      chk("R5 final backing image", 32'(nm), 32'd0);
    end
    finish_run();
  end

endmodule